// File: doc/BRIEF.md
# Standard Event Status Register

This block keeps eight sticky event flags for an instrument's status reporting. Each flag is set by a one-cycle pulse from an event source, such as a query error, and stays set until something clears it. An 8-bit enable mask selects which flags count toward a summary bit. That summary bit is placed at bit 5 of an 8-bit status byte. The other seven status-byte bits come from elsewhere and pass through unchanged.

A host reaches the block through a simple strobe interface. A select line picks either the event register or the enable mask. A read of the event register returns its contents and clears all eight flags in the same operation. A pulse that arrives in that same cycle is kept for the next read. A separate clear-status strobe also empties the event register. The enable mask is changed only by a host write or by reset.

Top module: `evt_status_reg`

## Requirements
- R1: After synchronous reset, the event flags, the enable mask and `host_rdata` are all zero, and `status_byte[5]` is 0.
- R2: A 1 on `evt_pulse[i]` at a clock edge sets event flag i. The flag stays 1 after the pulse ends, until a read of the event register, a clear-status or a reset. Each of the eight flags is independent of the others.
- R3: A query error arrives on `evt_pulse[2]` and sets flag 2 (value 8'h04).
- R4: `status_byte[5]` is 1 exactly when some flag and the matching mask bit are both 1. It follows a register change in the cycle after the edge that made the change. The other status-byte bits equal `sb_other` at the same positions.
- R5: A read strobe with `host_sel`=0 (event register) puts the flags' pre-read value on `host_rdata` after the edge. All eight flags are cleared at that edge.
- R6: A pulse in the same cycle as an event-register read does not appear in that read's data. Its flag is 1 after the read.
- R7: `clr_status` clears all flags. A pulse in the same cycle still leaves its flag set.
- R8: A write strobe with `host_sel`=1 loads `host_wdata` into the enable mask. A read strobe with `host_sel`=1 returns the mask on `host_rdata` and leaves the flags unchanged.
- R9: The enable mask is not changed by event-register reads or by clear-status.
- R10: A write strobe with `host_sel`=0 has no effect on the flags or on the mask.
- R11: `host_rdata` keeps its last value in cycles without a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_pulse | input | 8 | One-cycle event pulses, one per flag |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_sel | input | 1 | 0 = event register, 1 = enable mask |
| host_wdata | input | 8 | Host write data |
| clr_status | input | 1 | Clear-status command strobe |
| sb_other | input | 8 | Status-byte bits from other sources (bit 5 unused) |
| host_rdata | output | 8 | Registered read data |
| status_byte | output | 8 | Status byte with the event summary at bit 5 |

## Verification
The summary is tried with three kinds of stimulus. In the first, a flag is set while its mask bit is clear. In the second, the mask is changed under flags that are already set. In the third, the flags are cleared by a read or by clear-status. Together these show that the summary is an AND of flag and mask, not either one alone. Single-bit pulses are walked across all eight positions under a full mask, so crossed or merged bit lanes show up in the read data. Pulses that coincide with a read or with clear-status show whether set takes priority over clear. A mid-run reset and a mask read after the clears show that the mask is independent of the event path.

// File: rtl/evt_status_pkg.sv
package evt_status_pkg;
  parameter int EVT_W      = 8;
  parameter int SB_W       = 8;
  parameter int SUM_POS    = 5;
  parameter int QERR_BIT   = 2;

  typedef enum logic {
    SEL_EVENT = 1'b0,
    SEL_MASK  = 1'b1
  } host_sel_e;
endpackage

// File: rtl/evt_bit_bank.sv
module evt_bit_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_pulse,
  input  logic         clr_all,
  output logic [W-1:0] flags
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic flag_q;

    always_ff @(posedge clk) begin
      if (rst)
        flag_q <= 1'b0;
      else if (set_pulse[i])
        flag_q <= 1'b1;
      else if (clr_all)
        flag_q <= 1'b0;
    end

    assign flags[i] = flag_q;

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
      (flag_q && !clr_all) |=> flag_q); // R2
    AST_PULSE_WINS: assert property (@(posedge clk) disable iff (rst)
      set_pulse[i] |=> flag_q); // R6
  end

  AST_CLEAR_KEEPS_NEW: assert property (@(posedge clk) disable iff (rst)
    clr_all |=> (flags == $past(set_pulse))); // R7
endmodule

// File: rtl/evt_mask_reg.sv
module evt_mask_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] mask
);
  logic [W-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (rst)
      mask_q <= '0;
    else if (load)
      mask_q <= load_val;
  end

  assign mask = mask_q;

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(mask_q)); // R9
  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (rst)
    load |=> (mask_q == $past(load_val))); // R8
endmodule

// File: rtl/evt_rd_port.sv
module evt_rd_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rd,
  input  logic         sel_mask,
  input  logic [W-1:0] evt_val,
  input  logic [W-1:0] mask_val,
  output logic [W-1:0] rdata
);
  logic [W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (rst)
      rdata_q <= '0;
    else if (rd)
      rdata_q <= sel_mask ? mask_val : evt_val;
  end

  assign rdata = rdata_q;

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd |=> $stable(rdata_q)); // R11
endmodule

// File: rtl/evt_status_reg.sv
module evt_status_reg
  import evt_status_pkg::*;
#(
  parameter int EW   = EVT_W,
  parameter int SBW  = SB_W,
  parameter int SPOS = SUM_POS
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [EW-1:0]  evt_pulse,
  input  logic           host_rd,
  input  logic           host_wr,
  input  logic           host_sel,
  input  logic [EW-1:0]  host_wdata,
  input  logic           clr_status,
  input  logic [SBW-1:0] sb_other,
  output logic [EW-1:0]  host_rdata,
  output logic [SBW-1:0] status_byte
);
  logic [EW-1:0] evt_flags;
  logic [EW-1:0] en_mask;
  logic          rd_evt;
  logic          wr_mask;
  logic          evt_clr;
  logic          summary;

  assign rd_evt  = host_rd && (host_sel_e'(host_sel) == SEL_EVENT);
  assign wr_mask = host_wr && (host_sel_e'(host_sel) == SEL_MASK);
  assign evt_clr = rd_evt || clr_status;

  evt_bit_bank #(.W(EW)) u_bank (
    .clk       (clk),
    .rst       (rst),
    .set_pulse (evt_pulse),
    .clr_all   (evt_clr),
    .flags     (evt_flags)
  );

  evt_mask_reg #(.W(EW)) u_mask (
    .clk      (clk),
    .rst      (rst),
    .load     (wr_mask),
    .load_val (host_wdata),
    .mask     (en_mask)
  );

  evt_rd_port #(.W(EW)) u_rd (
    .clk      (clk),
    .rst      (rst),
    .rd       (host_rd),
    .sel_mask (host_sel),
    .evt_val  (evt_flags),
    .mask_val (en_mask),
    .rdata    (host_rdata)
  );

  assign summary = |(evt_flags & en_mask);

  always_comb begin
    status_byte       = sb_other;
    status_byte[SPOS] = summary;
  end

  AST_READ_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    rd_evt |=> (host_rdata == $past(evt_flags))); // R5
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (rd_evt && (evt_pulse == '0)) |=> (evt_flags == '0)); // R5
  AST_EVT_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (host_wr && !host_sel && !evt_clr && (evt_pulse == '0)) |=> $stable(evt_flags)); // R10
  AST_SUM_NEEDS_MASK: assert property (@(posedge clk) disable iff (rst)
    (en_mask == '0) |-> !status_byte[SPOS]); // R4
endmodule

// File: tb/evt_status_reg_bench.sv
module evt_status_reg_bench;
  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] evt_pulse;
  logic       host_rd, host_wr, host_sel, clr_status;
  logic [7:0] host_wdata, sb_other;
  logic [7:0] host_rdata, status_byte;

  int n_run  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  evt_status_reg u_evt_status_reg (
    .clk(clk), .rst(rst), .evt_pulse(evt_pulse), .host_rd(host_rd),
    .host_wr(host_wr), .host_sel(host_sel), .host_wdata(host_wdata),
    .clr_status(clr_status), .sb_other(sb_other),
    .host_rdata(host_rdata), .status_byte(status_byte)
  );

  typedef struct packed {
    logic [7:0] pulse;
    logic       rd;
    logic       wr;
    logic       sel;
    logic       clr;
    logic [7:0] wdata;
    logic [7:0] exp_rdata;
    logic       exp_sum;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 8'h05, 8'h00, 1'b0}, // R8 mask=05
    '{8'h04, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 1'b1}, // R3 query error
    '{8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 1'b1}, // R2 sticky
    '{8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h04, 1'b0}, // R5 read+clear
    '{8'h80, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h04, 1'b0}, // R4 unmasked flag
    '{8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 8'h05, 1'b0}, // R8 read mask
    '{8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 8'h80, 8'h05, 1'b1}, // R4 mask change
    '{8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 8'hFF, 8'h05, 1'b1}, // R10 ignored
    '{8'h02, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'h05, 1'b0}, // R7 clr+pulse
    '{8'h80, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h02, 1'b1}, // R6 read+pulse
    '{8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h80, 1'b0}, // R6 kept
    '{8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'h80, 1'b0}, // R7 clr
    '{8'h80, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h80, 1'b1}, // R9 mask kept
    '{8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 8'h80, 1'b1}  // R9 mask read
  };

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    evt_pulse = '0; host_rd = 0; host_wr = 0; host_sel = 0;
    clr_status = 0; host_wdata = '0;
  endtask

  task automatic step(input logic [7:0] p, input logic rd, input logic wr,
                      input logic sel, input logic clr, input logic [7:0] wd);
    @(negedge clk);
    evt_pulse = p; host_rd = rd; host_wr = wr; host_sel = sel;
    clr_status = clr; host_wdata = wd;
    @(posedge clk);
    #1;
    idle_inputs();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(posedge clk);
    #1;
    rst = 1'b0;
  endtask

  initial begin : watchdog
    #1000000;
    n_fail++;
    $display("FAIL watchdog expired actual=hang expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1;
    sb_other = 8'h00;
    idle_inputs();
    do_reset();

    // R1 reset state
    check8("R1 rdata", host_rdata, 8'h00);
    check8("R1 status", status_byte, 8'h00);
    step(8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00);
    check8("R1 mask", host_rdata, 8'h00);
    step(8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
    check8("R1 flags", host_rdata, 8'h00);

    for (int k = 0; k < NV; k++) begin
      step(VEC[k].pulse, VEC[k].rd, VEC[k].wr, VEC[k].sel, VEC[k].clr, VEC[k].wdata);
      check8($sformatf("R11/R5 vec%0d rdata", k), host_rdata, VEC[k].exp_rdata);
      check8($sformatf("R4 vec%0d summary", k), {7'd0, status_byte[5]}, {7'd0, VEC[k].exp_sum});
    end

    // R4 pass-through of the other status bits
    sb_other = 8'hFF;
    step(8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
    #1;
    check8("R4 passthrough", status_byte, 8'hDF);
    sb_other = 8'h00;

    // R2 bit independence, full mask
    step(8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 8'hFF);
    for (int b = 0; b < 8; b++) begin
      step(8'h01 << b, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
      check8("R2 summary on", {7'd0, status_byte[5]}, 8'h01);
      step(8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
      check8("R2 single bit", host_rdata, 8'h01 << b);
    end

    // R1 mid-run reset clears flags and mask
    step(8'h3C, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
    do_reset();
    check8("R1 rst summary", {7'd0, status_byte[5]}, 8'h00);
    step(8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00);
    check8("R1 rst mask", host_rdata, 8'h00);
    step(8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
    check8("R1 rst flags", host_rdata, 8'h00);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule